// File: doc/BRIEF.md
# Fixed-Coefficient First-Order Low-Pass Filter Bank

This block smooths a set of signed fixed-point sample streams with a first-order recursive low-pass response. Its intended use is pulling out the slowly varying (DC) part of quantities expressed in rotating reference frames. In that setting, ripple at twice the line frequency and at higher even multiples has to be removed before the values are fed back. Every lane holds its previous input and previous output. On each sample strobe it forms `y[n] = b0*x[n] + b1*x[n-1] + a1*y[n-1]` with Q15 coefficients. The default coefficients (803, 803, 31162) give a 40 Hz corner at a 5 kHz sample rate.

All lanes share one input strobe and one output strobe, so every filtered value in the bank changes on the same clock. The block runs from a fast system clock. A new sample arrives only once every many clocks, so the datapath can be narrow and shallow. A parameter chooses between a single-cycle update and a two-cycle update with a registered accumulator. Coefficients, widths, lane count and rounding mode are fixed when the block is built.

Top module: `iir_lp_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` goes low after that edge, `out_data` goes to zero, and every lane's stored previous input and previous output are cleared. The first sample after reset therefore yields round(b0*x/32768).
- R2: For each lane, on every strobe the output equals the saturated, rounded value of (B0*x[n] + B1*x[n-1] + A1*y[n-1]) / 2^15, computed exactly in integers. Lane k occupies bits [16k+15:16k] of `in_data` and `out_data`. The defaults are B0 = B1 = 803 and A1 = 31162.
- R3: With rounding enabled (the default), the scaled sum has 2^14 added before an arithmetic right shift by 15, so exact halves round toward +infinity. After reset, x = 16384 gives 402 and x = -16384 gives -401.
- R4: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R5: `out_valid` is a one-cycle pulse that appears exactly LAT clock edges after the edge that samples `in_valid`. LAT = 2 with PIPE = 1 (the default) and LAT = 1 with PIPE = 0. With PIPE = 1, strobes must be at least two clocks apart.
- R6: Between strobes, `out_data` holds its value. Changes on `in_data` while `in_valid` is low do not affect the output or the stored state.
- R7: All lanes are updated on the same clock edge under the single `out_valid`, and each lane's state depends only on its own input slice.
- R8: For a step input, every output stays within 16 LSB of a double-precision evaluation of 0.0245*x[n] + 0.0245*x[n-1] + 0.9510*y[n-1]. After 300 samples the output is within 16 LSB of the step level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_data | input | LANES*DATA_W | Packed signed Q15 input samples, lane 0 in the low bits |
| out_valid | output | 1 | Result strobe, one cycle, shared by all lanes |
| out_data | output | LANES*DATA_W | Packed signed Q15 filtered outputs, lane 0 in the low bits |

## Verification
The bound checker watches the strobe path on every cycle. It confirms that each input strobe produces exactly one result strobe after the fixed latency and that no result strobe appears without one. It also confirms that outputs hold still between results, that strobes respect the minimum spacing, and that reset clears the outputs. The arithmetic itself can only be shown by the bench's scenarios, which compare each lane against an exact integer recurrence and a floating-point reference. Those scenarios include the rounding of exact halves, saturation in a high-gain build, lanes driven with unlike data, and a long step that must settle.

// File: rtl/iir_lp_pkg.sv
package iir_lp_pkg;

   // Default Q15 coefficients: round(value * 32768)
   localparam int DEF_B0   = 803;     // 0.0245
   localparam int DEF_B1   = 803;     // 0.0245
   localparam int DEF_A1   = 31162;   // 0.9510
   localparam int DEF_FRAC = 15;

   typedef enum logic {
      RND_TRUNC   = 1'b0,
      RND_HALF_UP = 1'b1
   } iir_rnd_e;

endpackage

// File: rtl/iir_lp_strobe_pipe.sv
module iir_lp_strobe_pipe #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic take_i,
   output logic commit_o,
   output logic valid_o
);

   logic [LAT-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (rst) sr_q[0] <= 1'b0;
      else     sr_q[0] <= take_i;
   end

   for (genvar k = 1; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) sr_q[k] <= 1'b0;
         else     sr_q[k] <= sr_q[k-1];
      end
   end

   if (LAT == 1) begin : g_commit_now
      assign commit_o = take_i;
   end else begin : g_commit_late
      assign commit_o = sr_q[LAT-2];
   end

   assign valid_o = sr_q[LAT-1];

endmodule

// File: rtl/iir_lp_round_sat.sv
module iir_lp_round_sat #(
   parameter int ACC_W       = 34,
   parameter int FRAC        = 15,
   parameter int OUT_W       = 16,
   parameter bit RND_HALF_UP = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic signed [OUT_W-1:0] y_o
);

   localparam logic signed [ACC_W-1:0] HI =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] LO =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] HALF =
      {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] scaled;

   if (RND_HALF_UP) begin : g_half_up
      assign biased = acc_i + HALF;
   end else begin : g_trunc
      assign biased = acc_i;
   end

   assign scaled = biased >>> FRAC;

   always_comb begin
      if (scaled > HI)      y_o = HI[OUT_W-1:0];
      else if (scaled < LO) y_o = LO[OUT_W-1:0];
      else                  y_o = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/iir_lp_lane.sv
module iir_lp_lane #(
   parameter int DATA_W      = 16,
   parameter int COEF_W      = 16,
   parameter int FRAC        = 15,
   parameter int B0          = 803,
   parameter int B1          = 803,
   parameter int A1          = 31162,
   parameter int PIPE        = 1,
   parameter bit RND_HALF_UP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     take_i,
   input  logic                     commit_i,
   input  logic signed [DATA_W-1:0] x_i,
   output logic signed [DATA_W-1:0] y_o
);

   localparam int PROD_W = DATA_W + COEF_W;
   localparam int ACC_W  = PROD_W + 2;

   localparam logic signed [COEF_W-1:0] C_B0 = COEF_W'(B0);
   localparam logic signed [COEF_W-1:0] C_B1 = COEF_W'(B1);
   localparam logic signed [COEF_W-1:0] C_A1 = COEF_W'(A1);

   logic signed [DATA_W-1:0] x_prev_q;
   logic signed [DATA_W-1:0] y_q;
   logic signed [PROD_W-1:0] p_b0, p_b1, p_a1;
   logic signed [ACC_W-1:0]  sum;
   logic signed [ACC_W-1:0]  rs_in;
   logic signed [DATA_W-1:0] rs_out;

   always_comb begin
      p_b0 = PROD_W'(C_B0) * PROD_W'(x_i);
      p_b1 = PROD_W'(C_B1) * PROD_W'(x_prev_q);
      p_a1 = PROD_W'(C_A1) * PROD_W'(y_q);
      sum  = ACC_W'(p_b0) + ACC_W'(p_b1) + ACC_W'(p_a1);
   end

   always_ff @(posedge clk) begin
      if (rst)         x_prev_q <= '0;
      else if (take_i) x_prev_q <= x_i;
   end

   if (PIPE != 0) begin : g_two_cycle
      logic signed [ACC_W-1:0] acc_q;
      always_ff @(posedge clk) begin
         if (rst)         acc_q <= '0;
         else if (take_i) acc_q <= sum;
      end
      assign rs_in = acc_q;
   end else begin : g_one_cycle
      assign rs_in = sum;
   end

   iir_lp_round_sat #(
      .ACC_W       (ACC_W),
      .FRAC        (FRAC),
      .OUT_W       (DATA_W),
      .RND_HALF_UP (RND_HALF_UP)
   ) u_rs (
      .acc_i (rs_in),
      .y_o   (rs_out)
   );

   always_ff @(posedge clk) begin
      if (rst)           y_q <= '0;
      else if (commit_i) y_q <= rs_out;
   end

   assign y_o = y_q;

endmodule

// File: rtl/iir_lp_bank.sv
module iir_lp_bank #(
   parameter int LANES       = 4,
   parameter int DATA_W      = 16,
   parameter int COEF_W      = 16,
   parameter int FRAC        = iir_lp_pkg::DEF_FRAC,
   parameter int B0          = iir_lp_pkg::DEF_B0,
   parameter int B1          = iir_lp_pkg::DEF_B1,
   parameter int A1          = iir_lp_pkg::DEF_A1,
   parameter int PIPE        = 1,
   parameter bit RND_HALF_UP = iir_lp_pkg::RND_HALF_UP
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [LANES*DATA_W-1:0] in_data,
   output logic                    out_valid,
   output logic [LANES*DATA_W-1:0] out_data
);

   localparam int LAT      = (PIPE != 0) ? 2 : 1;
   localparam int COEF_MAX = (1 << (COEF_W - 1)) - 1;
   localparam int COEF_MIN = -(1 << (COEF_W - 1));

   if (LANES < 1) begin : g_bad_lanes
      $error("iir_lp_bank: LANES must be at least 1");
   end
   if (DATA_W < 4 || DATA_W > 30) begin : g_bad_data_w
      $error("iir_lp_bank: DATA_W out of range");
   end
   if (COEF_W < 4 || COEF_W > 30) begin : g_bad_coef_w
      $error("iir_lp_bank: COEF_W out of range");
   end
   if (FRAC < 1 || FRAC >= DATA_W + COEF_W) begin : g_bad_frac
      $error("iir_lp_bank: FRAC out of range");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_bad_pipe
      $error("iir_lp_bank: PIPE must be 0 or 1");
   end
   if (B0 > COEF_MAX || B0 < COEF_MIN ||
       B1 > COEF_MAX || B1 < COEF_MIN ||
       A1 > COEF_MAX || A1 < COEF_MIN) begin : g_bad_coef
      $error("iir_lp_bank: coefficient does not fit COEF_W");
   end

   logic commit;

   iir_lp_strobe_pipe #(
      .LAT (LAT)
   ) u_strobe (
      .clk      (clk),
      .rst      (rst),
      .take_i   (in_valid),
      .commit_o (commit),
      .valid_o  (out_valid)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      iir_lp_lane #(
         .DATA_W      (DATA_W),
         .COEF_W      (COEF_W),
         .FRAC        (FRAC),
         .B0          (B0),
         .B1          (B1),
         .A1          (A1),
         .PIPE        (PIPE),
         .RND_HALF_UP (RND_HALF_UP)
      ) u_lane (
         .clk      (clk),
         .rst      (rst),
         .take_i   (in_valid),
         .commit_i (commit),
         .x_i      (in_data[g*DATA_W +: DATA_W]),
         .y_o      (out_data[g*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/iir_lp_bank_chk.sv
module iir_lp_bank_chk #(
   parameter int LAT = 2,
   parameter int W   = 64
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic         out_valid,
   input logic [W-1:0] out_data
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (out_data == '0 && !out_valid));

   // R5
   lat_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##LAT out_valid);

   // R5
   lat_back_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, LAT));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));

   if (LAT > 1) begin : g_spacing
      // R5
      spacing_chk: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> !in_valid);
   end

endmodule

bind iir_lp_bank iir_lp_bank_chk #(
   .LAT ((PIPE != 0) ? 2 : 1),
   .W   (LANES * DATA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/iir_lp_bank_test.sv
module iir_lp_bank_test;

   localparam int CLK_PERIOD = 8;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [63:0]   in_data = '0;
   logic          out_valid;
   logic [63:0]   out_data;

   logic          s_valid = 1'b0;
   logic [15:0]   s_data = '0;
   logic          s_ovalid;
   logic [15:0]   s_odata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int  mx [NL];
   int  my [NL];
   real dx [NL];
   real dy [NL];
   int  sx, sy;

   always #(CLK_PERIOD/2) clk = ~clk;

   iir_lp_bank uut (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
      .out_valid (out_valid), .out_data (out_data)
   );

   iir_lp_bank #(
      .LANES (1), .B0 (16384), .B1 (16384), .A1 (16384), .PIPE (0)
   ) uut_hot (
      .clk (clk), .rst (rst), .in_valid (s_valid), .in_data (s_data),
      .out_valid (s_ovalid), .out_data (s_odata)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rnd_sat(longint acc);
      longint r = (acc + 64'sd16384) >>> 15;
      if (r > 32767)  return 32767;
      if (r < -32768) return -32768;
      return int'(r);
   endfunction

   function automatic int lane_out(int k);
      return int'($signed(out_data[k*16 +: 16]));
   endfunction

   task automatic model_clear();
      for (int k = 0; k < NL; k++) begin
         mx[k] = 0; my[k] = 0; dx[k] = 0.0; dy[k] = 0.0;
      end
      sx = 0; sy = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; s_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   // Drives one sample on all lanes of uut and checks exact results.
   task automatic push4(int a, int b, int c, int d, string tag, bit dbl);
      int v [NL];
      int e [NL];
      v[0] = a; v[1] = b; v[2] = c; v[3] = d;
      for (int k = 0; k < NL; k++) begin
         e[k] = rnd_sat(longint'(803) * v[k] + longint'(803) * mx[k]
                        + longint'(31162) * my[k]);
         dy[k] = 0.0245 * v[k] + 0.0245 * dx[k] + 0.9510 * dy[k];
         dx[k] = real'(v[k]);
         mx[k] = v[k];
         my[k] = e[k];
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data = {16'(d), 16'(c), 16'(b), 16'(a)};
      @(negedge clk);
      in_valid = 1'b0;
      chk({"R5 no strobe after one edge ", tag}, int'(out_valid), 0);
      @(negedge clk);
      chk({"R5 strobe after two edges ", tag}, int'(out_valid), 1);
      for (int k = 0; k < NL; k++) begin
         chk($sformatf("R2 R7 lane%0d %s", k, tag), lane_out(k), e[k]);
         if (dbl) begin
            real err = real'(lane_out(k)) - dy[k];
            n_chk++;
            if (err > 16.0 || err < -16.0) begin
               n_bad++;
               $display("FAIL R8 lane%0d actual=%0d expected=%0f", k,
                        lane_out(k), dy[k]);
            end
         end
      end
      @(negedge clk);
      chk({"R5 single pulse ", tag}, int'(out_valid), 0);
   endtask

   task automatic push_hot(int v);
      int e;
      e = rnd_sat(longint'(16384) * v + longint'(16384) * sx
                  + longint'(16384) * sy);
      sx = v; sy = e;
      @(negedge clk);
      s_valid = 1'b1; s_data = 16'(v);
      @(negedge clk);
      s_valid = 1'b0;
      chk("R5 one-cycle build strobe", int'(s_ovalid), 1);
      chk("R4 saturated value", int'($signed(s_odata)), e);
      @(negedge clk);
      chk("R5 one-cycle build pulse", int'(s_ovalid), 0);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      for (int k = 0; k < NL; k++) chk("R1 out_data after reset", lane_out(k), 0);
      push4(1000, -1000, 0, 32767, "R1 first sample", 1'b0);
      chk("R1 lane0 first value", lane_out(0), 25);
   endtask

   task automatic t_impulse();
      do_reset();
      push4(10000, -10000, 0, 32767, "impulse", 1'b0);
      for (int i = 0; i < 12; i++) push4(0, 0, 0, 0, "impulse tail", 1'b0);
   endtask

   task automatic t_round();
      do_reset();
      push4(16384, -16384, 1, 21, "R3 halves", 1'b0);
      chk("R3 +half rounds up", lane_out(0), 402);
      chk("R3 -half rounds up", lane_out(1), -401);
      chk("R3 tiny rounds to zero", lane_out(2), 0);
      chk("R3 above half", lane_out(3), 1);
   endtask

   task automatic t_hold();
      int held [NL];
      push4(5000, 7000, -3000, 123, "R6 before", 1'b0);
      for (int k = 0; k < NL; k++) held[k] = lane_out(k);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_data = {16'(i * 911), 16'(-i * 77), 16'(32767 - i), 16'(i)};
      end
      @(negedge clk);
      chk("R6 no strobe while idle", int'(out_valid), 0);
      for (int k = 0; k < NL; k++) chk("R6 output held", lane_out(k), held[k]);
      push4(5000, 7000, -3000, 123, "R6 state untouched", 1'b0);
   endtask

   task automatic t_step();
      do_reset();
      for (int i = 0; i < 300; i++)
         push4(20000, -20000, 32767, -32768, "R8 step", 1'b1);
      chk("R8 settle lane0", (lane_out(0) - 20000 <= 16 && 20000 - lane_out(0) <= 16), 1);
      chk("R8 settle lane1", (lane_out(1) + 20000 <= 16 && -20000 - lane_out(1) <= 16), 1);
      chk("R8 settle lane2", (32767 - lane_out(2) <= 16), 1);
      chk("R8 settle lane3", (lane_out(3) + 32768 <= 16), 1);
   endtask

   task automatic t_sat();
      do_reset();
      for (int i = 0; i < 4; i++) push_hot(32767);
      chk("R4 clamp high", int'($signed(s_odata)), 32767);
      for (int i = 0; i < 8; i++) push_hot(-32768);
      chk("R4 clamp low", int'($signed(s_odata)), -32768);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      model_clear();
      t_reset();
      t_impulse();
      t_round();
      t_hold();
      t_sat();
      t_step();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule